// File: doc/BRIEF.md
# Input-Order Edge Discriminator

This block watches two asynchronous level inputs, `sig_a` and `sig_b`, and reports which of them came up second, that is, which one rose while its partner was already high. Both inputs first pass through a multi-flop synchroniser. The synchronised levels are then compared with the levels held from the previous clock to find rising edges. A two-bit order code records the answer. It keeps that answer through later changes that do not matter, and it returns to zero once both inputs are low again.

Each time the order code takes a new value, the block raises a one-cycle `change_o` strobe, so a consumer only has to act on strobes. If both inputs rise in the same synchronised sample, their order cannot be known. In that case the code is left as it was and a one-cycle `both_rose_o` flag is raised.

Top module: `order_edge_discriminator`

## Requirements
- R1: When both synchronised inputs are low, the order code becomes 00 on the next clock edge.
- R2: A rising edge of `sig_a` while `sig_b` is high sets the order code to 10 (bit 1 set means `sig_a` rose last). The code never takes the value 11.
- R3: A rising edge of `sig_b` while `sig_a` is high sets the order code to 01 (bit 0 set means `sig_b` rose last).
- R4: In every other case the order code keeps its value. This covers a falling edge while the other input stays high, and a rising edge while the other input is low.
- R5: `change_o` is high for exactly the one cycle in which the order code holds a value different from the one it held in the cycle before.
- R6: If both inputs rise in the same synchronised sample, the order code is held and `both_rose_o` is high for one cycle.
- R7: A change of an input level is reflected on the outputs `SYNC_STAGES + 1` rising clock edges after it is applied (3 edges with the default of 2).
- R8: While `rst_n` is low, the order code is 00, `change_o` and `both_rose_o` are 0, and the synchroniser and edge-history registers are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_a | input | 1 | First asynchronous level input |
| sig_b | input | 1 | Second asynchronous level input |
| code_o | output | 2 | Order code: 00 none, 10 `sig_a` rose last, 01 `sig_b` rose last |
| change_o | output | 1 | One-cycle strobe when `code_o` takes a new value |
| both_rose_o | output | 1 | One-cycle flag when both inputs rose in the same sample |

## Verification
The bench drives the input pairs through every ordering and checks the outputs at the exact edge where the result should appear. It covers each input rising second, falling edges with the partner still high, a rise with the partner low, and a direct swap from 10 to 01 without passing through 00. A design that confused the two bits, or treated a falling edge as an event, would change the code when it should hold it. A design that used the raw levels instead of edges would never keep the code across an unrelated change. The simultaneous-rise case catches a design that lets one input win silently, and the one-cycle strobe checks catch a design that holds `change_o` high or pulses it on a hold.

// File: rtl/order_pkg.sv
package order_pkg;

    // Order code values; bit 1 marks input A rising last, bit 0 marks input B.
    typedef enum logic [1:0] {
        CODE_NONE   = 2'b00,
        CODE_B_LAST = 2'b01,
        CODE_A_LAST = 2'b10
    } order_code_e;

    localparam int unsigned NUM_INPUTS = 2;
    localparam int unsigned IDX_A      = 0;
    localparam int unsigned IDX_B      = 1;

    typedef struct packed {
        order_code_e code;
        logic        change;
        logic        both_rose;
    } order_state_t;

endpackage

// File: rtl/order_sync.sv
module order_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i[g];
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[g] = chain_q[LAST];
    end

endmodule

// File: rtl/order_edge.sv
module order_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/order_decide.sv
module order_decide
    import order_pkg::*;
(
    input  logic [NUM_INPUTS-1:0] level_i,
    input  logic [NUM_INPUTS-1:0] rise_i,
    input  order_code_e           code_q_i,
    output order_state_t          state_d_o
);

    logic both_low;
    logic both_rise;
    logic a_second;
    logic b_second;

    always_comb begin
        both_low  = ~level_i[IDX_A] & ~level_i[IDX_B];
        both_rise = rise_i[IDX_A] & rise_i[IDX_B];
        a_second  = rise_i[IDX_A] & level_i[IDX_B];
        b_second  = rise_i[IDX_B] & level_i[IDX_A];

        state_d_o.code      = code_q_i;
        state_d_o.both_rose = 1'b0;

        if (both_low) begin
            state_d_o.code = CODE_NONE;
        end else if (both_rise) begin
            state_d_o.both_rose = 1'b1;
        end else if (a_second) begin
            state_d_o.code = CODE_A_LAST;
        end else if (b_second) begin
            state_d_o.code = CODE_B_LAST;
        end

        state_d_o.change = (state_d_o.code != code_q_i);
    end

endmodule

// File: rtl/order_edge_discriminator.sv
module order_edge_discriminator
    import order_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_a,
    input  logic       sig_b,
    output logic [1:0] code_o,
    output logic       change_o,
    output logic       both_rose_o
);

    logic [NUM_INPUTS-1:0] async_vec;
    logic [NUM_INPUTS-1:0] sync_lvl;
    logic [NUM_INPUTS-1:0] rise_vec;
    order_state_t          state_d;
    order_state_t          state_q;

    assign async_vec[IDX_A] = sig_a;
    assign async_vec[IDX_B] = sig_b;

    order_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NUM_INPUTS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_vec),
        .sync_o  (sync_lvl)
    );

    order_edge #(
        .WIDTH (NUM_INPUTS)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_lvl),
        .rise_o  (rise_vec)
    );

    order_decide u_decide (
        .level_i   (sync_lvl),
        .rise_i    (rise_vec),
        .code_q_i  (state_q.code),
        .state_d_o (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{code: CODE_NONE, change: 1'b0, both_rose: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign code_o      = state_q.code;
    assign change_o    = state_q.change;
    assign both_rose_o = state_q.both_rose;

endmodule

// File: rtl/order_edge_chk.sv
module order_edge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] lvl,
    input logic [1:0] rise,
    input logic [1:0] code,
    input logic       change,
    input logic       both
);

    // R1: both synchronised levels low clears the code
    a_r1_clear_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'b00) |=> (code == 2'b00));

    // R2: A rises second
    a_r2_a_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[0] && !rise[1] && lvl[1]) |=> (code == 2'b10));

    // R2: illegal code never appears
    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        code != 2'b11);

    // R3: B rises second
    a_r3_b_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[1] && !rise[0] && lvl[0]) |=> (code == 2'b01));

    // R4: no qualifying event holds the code
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != 2'b00 && !(rise[0] && lvl[1]) && !(rise[1] && lvl[0])) |=> $stable(code));

    // R5: change strobe tracks a new code value
    a_r5_change_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (change == (code != $past(code))));

    // R6: simultaneous rise flags and holds
    a_r6_both_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rise == 2'b11) |=> (both && $stable(code)));

    // R6: flag only after a simultaneous rise
    a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != 2'b11) |=> !both);

endmodule

bind order_edge_discriminator order_edge_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (sync_lvl),
    .rise   (rise_vec),
    .code   (code_o),
    .change (change_o),
    .both   (both_rose_o)
);

// File: tb/order_edge_discriminator_tb.sv
module order_edge_discriminator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 3; // SYNC_STAGES + 1 edges (R7)
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_a = 1'b0;
    logic       sig_b = 1'b0;
    logic [1:0] code_o;
    logic       change_o;
    logic       both_rose_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] last_exp = 2'b00;

    typedef struct {
        int         due;
        logic [1:0] code;
        logic       chg;
        logic       err;
        string      tag;
    } item_t;

    item_t sb_q[$];

    order_edge_discriminator u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_a       (sig_a),
        .sig_b       (sig_b),
        .code_o      (code_o),
        .change_o    (change_o),
        .both_rose_o (both_rose_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: called at a negedge; pushes the result edge and the following idle cycle
    task automatic apply(input logic a, input logic b, input logic [1:0] exp_code,
                         input logic exp_err, input string tag);
        item_t it;
        sig_a = a;
        sig_b = b;
        it.due  = cyc + LATENCY;
        it.code = exp_code;
        it.chg  = (exp_code != last_exp);
        it.err  = exp_err;
        it.tag  = tag;
        sb_q.push_back(it);
        it.due  = cyc + LATENCY + 1;
        it.chg  = 1'b0;
        it.err  = 1'b0;
        it.tag  = {tag, " R5 one-cycle"};
        sb_q.push_back(it);
        last_exp = exp_code;
        repeat (6) @(negedge clk);
    endtask

    // Monitor: compares when each expected item falls due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (it.due != cyc || code_o !== it.code || change_o !== it.chg
                || both_rose_o !== it.err) begin
                errors++;
                $display("FAIL %s: actual code=%b chg=%b err=%b expected code=%b chg=%b err=%b",
                         it.tag, code_o, change_o, both_rose_o, it.code, it.chg, it.err);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (code_o !== 2'b00 || change_o !== 1'b0 || both_rose_o !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset: actual code=%b chg=%b err=%b expected 00 0 0",
                     code_o, change_o, both_rose_o);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        apply(1'b1, 1'b0, 2'b00, 1'b0, "R4 a rises with b low");
        apply(1'b1, 1'b1, 2'b01, 1'b0, "R3 b rises while a high R7");
        apply(1'b0, 1'b1, 2'b01, 1'b0, "R4 a falls, b high");
        apply(1'b1, 1'b1, 2'b10, 1'b0, "R2 a rises while b high");
        apply(1'b1, 1'b0, 2'b10, 1'b0, "R4 b falls, a high");
        apply(1'b0, 1'b0, 2'b00, 1'b0, "R1 both low");
        apply(1'b1, 1'b1, 2'b00, 1'b1, "R6 both rise together");
        apply(1'b0, 1'b1, 2'b00, 1'b0, "R4 a falls after tie");
        apply(1'b1, 1'b1, 2'b10, 1'b0, "R2 a second after tie");
        apply(1'b0, 1'b0, 2'b00, 1'b0, "R1 both fall together");
        apply(1'b0, 1'b1, 2'b00, 1'b0, "R4 b rises with a low");
        apply(1'b1, 1'b1, 2'b10, 1'b0, "R2 a rises second again");
        apply(1'b1, 1'b0, 2'b10, 1'b0, "R4 b drops");
        apply(1'b1, 1'b1, 2'b01, 1'b0, "R3 swap 10 to 01 directly");
        apply(1'b0, 1'b1, 2'b01, 1'b0, "R4 a drops after 01");
        apply(1'b1, 1'b1, 2'b10, 1'b0, "R2 swap 01 to 10 directly");
        apply(1'b0, 1'b0, 2'b00, 1'b0, "R1 final clear");

        // Reset in the middle of activity (R8)
        apply(1'b1, 1'b0, 2'b00, 1'b0, "R4 a alone");
        apply(1'b1, 1'b1, 2'b01, 1'b0, "R3 before reset");
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (code_o !== 2'b00 || change_o !== 1'b0 || both_rose_o !== 1'b0) begin
            errors++;
            $display("FAIL R8 mid-run reset: actual code=%b chg=%b err=%b expected 00 0 0",
                     code_o, change_o, both_rose_o);
        end
        sig_a = 1'b0;
        sig_b = 1'b0;
        last_exp = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        apply(1'b0, 1'b1, 2'b00, 1'b0, "R8 history cleared, b alone");
        apply(1'b1, 1'b1, 2'b10, 1'b0, "R2 after reset");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule